// File: doc/BRIEF.md
# CPU Standby Power-Mode Controller

This block decides when a small CPU core may stop its clocks and which clock and function domains are shut down while it waits. The instruction decoder sends one-cycle requests for halt and for sleep. A control bit chooses between a light halt and a deep halt. The controller then moves into one of three standby levels, and each level drives its own set of enable outputs. These cover the CPU clock, the bus clock, the external bus control logic, DMA availability, the high-speed oscillator, and the peripherals that run on the fast clock.

Wake sources are sampled as levels: NMI, the clock-timer interrupt, external interrupt lines, and interrupts from fast-clock peripherals. The interrupt-enable flag of the status register gates every wake source except NMI. Fast-clock peripheral interrupts cannot wake the core from sleep. Reset is not a wake source; it returns the controller to run at once.

A wake from sleep goes through two steps. The controller first turns the high-speed oscillator back on. It then counts a programmable number of low-speed ticks before it lets the CPU clock run. Every wake then gives a one-cycle wake strobe with all enables restored, followed by a one-cycle trap request. The trap logic uses the stored resume address, which is the address of the instruction after the standby instruction.

Top module: `standby_ctrl`

## Requirements
- R1: While rst_n is low, and from the moment it falls with no clock edge needed, the controller is in run: all six enable outputs are 1 and wake_pulse and trap_req are 0.
- R2: A halt_req pulse with deep_halt_sel=0 enters light halt. cpu_clk_en=0 and dma_avail=0. bus_clk_en, bus_ctrl_en, hosc_en and fperiph_en stay 1.
- R3: A halt_req pulse with deep_halt_sel=1 enters deep halt. cpu_clk_en, bus_clk_en, bus_ctrl_en and dma_avail are 0. hosc_en and fperiph_en stay 1.
- R4: A sleep_req pulse enters sleep, and all six enables become 0. If sleep_req and halt_req arrive in the same cycle, sleep is taken.
- R5: Either halt level wakes on nmi, or on any of ctimer_irq, ext_irq or periph_irq while psr_ie=1.
- R6: Sleep wakes on nmi, or on ctimer_irq or ext_irq while psr_ie=1. periph_irq has no effect in sleep.
- R7: While psr_ie=0, only nmi ends a standby level.
- R8: After a sleep wake, hosc_en is 1 while cpu_clk_en and fperiph_en stay 0. The CPU clock is released only after settle_cnt slow_tick pulses have been counted. With settle_cnt=0, release follows one cycle later.
- R9: Every wake gives wake_pulse for exactly one cycle with all enables at 1. trap_req follows for exactly one cycle in the next cycle, and then the controller is back in run.
- R10: On an accepted standby request, resume_addr takes the value of next_pc. It holds that value until the next accepted request.
- R11: If a wake condition for the requested level is already present when the request arrives, no enable is dropped and wake_pulse is raised in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle halt request from the decoder |
| sleep_req | input | 1 | One-cycle sleep request from the decoder |
| deep_halt_sel | input | 1 | 1 selects deep halt for halt_req |
| next_pc | input | AW | Address of the instruction after the standby instruction |
| nmi | input | 1 | Non-maskable interrupt level |
| ctimer_irq | input | 1 | Clock-timer interrupt level |
| ext_irq | input | EXT_W | External interrupt levels |
| periph_irq | input | PER_W | Fast-clock peripheral interrupt levels |
| psr_ie | input | 1 | Status-register interrupt enable |
| settle_cnt | input | CW | Oscillator settle time in slow ticks |
| slow_tick | input | 1 | One pulse per low-speed clock period |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| bus_ctrl_en | output | 1 | External bus control enable |
| dma_avail | output | 1 | DMA may be used |
| hosc_en | output | 1 | High-speed oscillator enable |
| fperiph_en | output | 1 | Fast-clock peripheral enable |
| wake_pulse | output | 1 | One-cycle wake strobe |
| trap_req | output | 1 | One-cycle trap-entry request |
| resume_addr | output | AW | Return address for trap entry |

## Verification
The bound checker tests four behaviours on every clock cycle:
- The strobe-then-trap order of a wake, and that each strobe lasts one cycle with all enables raised.
- That the bus control logic is never off while DMA is reported as available.
- That the resume address does not move while the CPU clock is stopped.
- That sleep with the interrupt enable clear persists until NMI arrives.

The bench scenarios cover the rest:
- The gating pattern of each standby level, read at the ports.
- The wake filter across sources, levels and the enable flag, including peripheral interrupts being ignored in sleep.
- The exact number of slow ticks counted before release.
- The immediate-wake path.
- Sleep winning over halt.
- Reset taking effect with no clock edge.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_HALT   = 3'd1,
    ST_HALT2  = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_WAKE   = 3'd5,
    ST_TRAP   = 3'd6
  } stby_state_e;

  typedef struct packed {
    logic cpu;
    logic bus_clk;
    logic bus_ctrl;
    logic dma;
    logic hosc;
    logic fper;
  } gate_t;

endpackage

// File: rtl/stby_wake_filter.sv
module stby_wake_filter #(
  parameter int EXT_W = 4,
  parameter int PER_W = 8
) (
  input  logic             sleep_lvl,
  input  logic             nmi,
  input  logic             ctimer_irq,
  input  logic [EXT_W-1:0] ext_irq,
  input  logic [PER_W-1:0] periph_irq,
  input  logic             psr_ie,
  output logic             wake
);

  logic slow_src;
  logic fast_src;

  always_comb begin
    slow_src = ctimer_irq | (|ext_irq);
    // fast-clock peripherals are silent while their clock is stopped
    fast_src = (|periph_irq) & ~sleep_lvl;
    wake     = nmi | (psr_ie & (slow_src | fast_src));
  end

endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = run & (cnt_q >= limit);
    cnt_en = ~run | (tick & ~done);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/stby_gate_decode.sv
module stby_gate_decode
  import stby_pkg::*;
(
  input  stby_state_e state,
  output gate_t       gates
);

  always_comb begin
    gates = '{cpu: 1'b1, bus_clk: 1'b1, bus_ctrl: 1'b1,
              dma: 1'b1, hosc: 1'b1, fper: 1'b1};
    case (state)
      ST_HALT: begin
        gates.cpu = 1'b0;
        gates.dma = 1'b0;
      end
      ST_HALT2: begin
        gates.cpu      = 1'b0;
        gates.bus_clk  = 1'b0;
        gates.bus_ctrl = 1'b0;
        gates.dma      = 1'b0;
      end
      ST_SLEEP: begin
        gates = '0;
      end
      ST_SETTLE: begin
        gates      = '0;
        gates.hosc = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int EXT_W = 4,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             sleep_req,
  input  logic             deep_halt_sel,
  input  logic [AW-1:0]    next_pc,
  input  logic             nmi,
  input  logic             ctimer_irq,
  input  logic [EXT_W-1:0] ext_irq,
  input  logic [PER_W-1:0] periph_irq,
  input  logic             psr_ie,
  input  logic [CW-1:0]    settle_cnt,
  input  logic             slow_tick,
  output logic             cpu_clk_en,
  output logic             bus_clk_en,
  output logic             bus_ctrl_en,
  output logic             dma_avail,
  output logic             hosc_en,
  output logic             fperiph_en,
  output logic             wake_pulse,
  output logic             trap_req,
  output logic [AW-1:0]    resume_addr
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  stby_state_e state_q, state_d;
  logic [AW-1:0] resume_q;
  logic          req_any;
  logic          req_accept;
  logic          sleep_lvl;
  logic          wake;
  logic          settle_done;
  gate_t         gates;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  always_comb begin
    req_any    = halt_req | sleep_req;
    req_accept = (state_q == ST_RUN) & req_any;
    sleep_lvl  = (state_q == ST_SLEEP) | ((state_q == ST_RUN) & sleep_req);
  end

  stby_wake_filter #(.EXT_W(EXT_W), .PER_W(PER_W)) u_filter (
    .sleep_lvl  (sleep_lvl),
    .nmi        (nmi),
    .ctimer_irq (ctimer_irq),
    .ext_irq    (ext_irq),
    .periph_irq (periph_irq),
    .psr_ie     (psr_ie),
    .wake       (wake)
  );

  stby_settle_timer #(.CW(CW)) u_settle (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (state_q == ST_SETTLE),
    .tick  (slow_tick),
    .limit (settle_cnt),
    .done  (settle_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (req_any) begin
          if (wake)               state_d = ST_WAKE;
          else if (sleep_req)     state_d = ST_SLEEP;
          else if (deep_halt_sel) state_d = ST_HALT2;
          else                    state_d = ST_HALT;
        end
      end
      ST_HALT, ST_HALT2: if (wake) state_d = ST_WAKE;
      ST_SLEEP:          if (wake) state_d = ST_SETTLE;
      ST_SETTLE:         if (settle_done) state_d = ST_WAKE;
      ST_WAKE:           state_d = ST_TRAP;
      default:           state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      resume_q <= '0;
    end else if (req_accept) begin
      resume_q <= next_pc;
    end
  end

  stby_gate_decode u_gates (
    .state (state_q),
    .gates (gates)
  );

  assign cpu_clk_en  = gates.cpu;
  assign bus_clk_en  = gates.bus_clk;
  assign bus_ctrl_en = gates.bus_ctrl;
  assign dma_avail   = gates.dma;
  assign hosc_en     = gates.hosc;
  assign fperiph_en  = gates.fper;
  assign wake_pulse  = (state_q == ST_WAKE);
  assign trap_req    = (state_q == ST_TRAP);
  assign resume_addr = resume_q;

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi,
  input logic          psr_ie,
  input logic          cpu_clk_en,
  input logic          bus_clk_en,
  input logic          bus_ctrl_en,
  input logic          dma_avail,
  input logic          hosc_en,
  input logic          fperiph_en,
  input logic          wake_pulse,
  input logic          trap_req,
  input logic [AW-1:0] resume_addr
);

  AST_TRAP_FOLLOWS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> trap_req); // R9

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R9

  AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req); // R9

  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (cpu_clk_en && bus_clk_en && bus_ctrl_en && dma_avail
                    && hosc_en && fperiph_en)); // R9

  AST_DMA_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ctrl_en |-> !dma_avail); // R3

  AST_SLEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !hosc_en |-> (!cpu_clk_en && !fperiph_en && !bus_clk_en)); // R4

  AST_SLEEP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hosc_en && !nmi && !psr_ie) |=> !hosc_en); // R7

  AST_RESUME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && $past(!cpu_clk_en)) |-> $stable(resume_addr)); // R10

endmodule

bind standby_ctrl stby_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi         (nmi),
  .psr_ie      (psr_ie),
  .cpu_clk_en  (cpu_clk_en),
  .bus_clk_en  (bus_clk_en),
  .bus_ctrl_en (bus_ctrl_en),
  .dma_avail   (dma_avail),
  .hosc_en     (hosc_en),
  .fperiph_en  (fperiph_en),
  .wake_pulse  (wake_pulse),
  .trap_req    (trap_req),
  .resume_addr (resume_addr)
);

// File: tb/tb_standby_ctrl.sv
module tb_standby_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 32;
  localparam int CW    = 8;
  localparam int EXT_W = 4;
  localparam int PER_W = 8;
  localparam int NVEC  = 12;

  // vector: [7:6] level (0 halt, 1 deep halt, 2 sleep), [5] nmi, [4] ctimer,
  //         [3] ext, [2] periph, [1] psr_ie, [0] expected wake
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00_0_0_1_0_1_1,
    8'b00_0_0_0_1_1_1,
    8'b00_0_0_1_0_0_0,
    8'b00_1_0_0_0_0_1,
    8'b01_0_1_0_0_1_1,
    8'b01_0_0_0_1_0_0,
    8'b10_0_0_0_1_1_0,
    8'b10_0_1_0_0_1_1,
    8'b10_0_0_1_0_1_1,
    8'b10_0_0_1_0_0_0,
    8'b10_1_0_0_0_0_1,
    8'b01_0_0_0_1_1_1
  };

  logic             clk;
  logic             rst_n;
  logic             halt_req, sleep_req, deep_halt_sel;
  logic [AW-1:0]    next_pc;
  logic             nmi, ctimer_irq, psr_ie, slow_tick;
  logic [EXT_W-1:0] ext_irq;
  logic [PER_W-1:0] periph_irq;
  logic [CW-1:0]    settle_cnt;
  logic             cpu_clk_en, bus_clk_en, bus_ctrl_en, dma_avail, hosc_en, fperiph_en;
  logic             wake_pulse, trap_req;
  logic [AW-1:0]    resume_addr;

  int  n_tests;
  int  n_fail;
  bit  finished;

  standby_ctrl #(.AW(AW), .CW(CW), .EXT_W(EXT_W), .PER_W(PER_W)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .deep_halt_sel(deep_halt_sel), .next_pc(next_pc), .nmi(nmi),
    .ctimer_irq(ctimer_irq), .ext_irq(ext_irq), .periph_irq(periph_irq),
    .psr_ie(psr_ie), .settle_cnt(settle_cnt), .slow_tick(slow_tick),
    .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .bus_ctrl_en(bus_ctrl_en),
    .dma_avail(dma_avail), .hosc_en(hosc_en), .fperiph_en(fperiph_en),
    .wake_pulse(wake_pulse), .trap_req(trap_req), .resume_addr(resume_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] gates_now();
    return {cpu_clk_en, bus_clk_en, bus_ctrl_en, dma_avail, hosc_en, fperiph_en};
  endfunction

  // expected {cpu, bus_clk, bus_ctrl, dma, hosc, fper} per level
  function automatic logic [5:0] gates_exp(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 6'b011011;
      2'd1:    return 6'b000011;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    halt_req = 0; sleep_req = 0; nmi = 0; ctimer_irq = 0;
    ext_irq = '0; periph_irq = '0; slow_tick = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 0;
    clear_inputs();
    deep_halt_sel = 0; psr_ie = 0; settle_cnt = '0; next_pc = 32'h100;
    rst_n = 0;
    repeat (3) cycle();
    // R1: reset state
    check(gates_now() == 6'h3f && !wake_pulse && !trap_req, "R1 reset state",
          {gates_now(), wake_pulse, trap_req}, {6'h3f, 2'b00});
    rst_n = 1;
    repeat (4) cycle();

    // table of level / wake-source combinations
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] t;
      int pulses;
      t = VEC[v];
      psr_ie        = t[1];
      deep_halt_sel = (t[7:6] == 2'd1);
      if (t[7:6] == 2'd2) sleep_req = 1; else halt_req = 1;
      cycle();
      halt_req = 0; sleep_req = 0;
      check(gates_now() == gates_exp(t[7:6]),
            t[7:6] == 2'd0 ? "R2 light halt gates" :
            (t[7:6] == 2'd1 ? "R3 deep halt gates" : "R4 sleep gates"),
            gates_now(), gates_exp(t[7:6]));
      nmi = t[5]; ctimer_irq = t[4];
      ext_irq = t[3] ? 4'b0010 : '0;
      periph_irq = t[2] ? 8'h10 : '0;
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
        cycle();
        if (wake_pulse) pulses++;
      end
      clear_inputs();
      check(pulses == (t[0] ? 1 : 0),
            !t[1] ? "R7 masked wake filter" :
            (t[7:6] == 2'd2 ? "R6 sleep wake filter" : "R5 halt wake filter"),
            pulses, t[0] ? 1 : 0);
      if (!t[0]) begin
        nmi = 1;
        cycle();
        nmi = 0;
        repeat (6) cycle();
      end
      check(cpu_clk_en == 1'b1, "R9 back in run", cpu_clk_en, 1);
    end

    // R9 and R10: wake sequence and resume address
    psr_ie = 1; deep_halt_sel = 0; next_pc = 32'h0000_1234;
    halt_req = 1;
    cycle();
    halt_req = 0; next_pc = 32'h0000_9999;
    check(cpu_clk_en == 0, "R2 halt entered", cpu_clk_en, 0);
    ext_irq = 4'b0001;
    cycle();
    ext_irq = '0;
    check(wake_pulse && !trap_req && gates_now() == 6'h3f, "R9 wake strobe with enables",
          {gates_now(), wake_pulse, trap_req}, {6'h3f, 2'b10});
    cycle();
    check(!wake_pulse && trap_req, "R9 trap after wake", {wake_pulse, trap_req}, 2'b01);
    cycle();
    check(!trap_req, "R9 trap one cycle", trap_req, 0);
    check(resume_addr == 32'h0000_1234, "R10 resume address", resume_addr, 32'h1234);

    // R11: immediate wake when a source is already pending
    next_pc = 32'h0000_2000;
    ctimer_irq = 1; halt_req = 1;
    cycle();
    halt_req = 0; ctimer_irq = 0;
    check(wake_pulse && cpu_clk_en, "R11 immediate wake", {wake_pulse, cpu_clk_en}, 2'b11);
    check(resume_addr == 32'h0000_2000, "R10 captured on immediate wake",
          resume_addr, 32'h2000);
    repeat (3) cycle();

    // R11: periph pending does not count for a sleep request
    periph_irq = 8'h01; sleep_req = 1;
    cycle();
    sleep_req = 0;
    check(!wake_pulse && !hosc_en, "R11 sleep not cancelled by periph",
          {wake_pulse, hosc_en}, 2'b00);
    periph_irq = '0;
    nmi = 1; cycle(); nmi = 0;
    repeat (6) cycle();

    // R4: sleep wins over halt
    halt_req = 1; sleep_req = 1; deep_halt_sel = 1;
    cycle();
    halt_req = 0; sleep_req = 0;
    check(gates_now() == 6'b000000, "R4 sleep priority", gates_now(), 0);

    // R8: oscillator settle count
    settle_cnt = 8'd3;
    ctimer_irq = 1;
    cycle();
    ctimer_irq = 0;
    check(hosc_en && !cpu_clk_en && !fperiph_en, "R8 oscillator first",
          {hosc_en, cpu_clk_en, fperiph_en}, 3'b100);
    begin
      int ticks;
      int seen_at;
      ticks = 0; seen_at = -1;
      for (int i = 0; i < 40; i++) begin
        slow_tick = (i % 4 == 3);
        if (slow_tick) ticks++;
        cycle();
        if (wake_pulse && seen_at < 0) begin
          seen_at = ticks;
          break;
        end
        if (!wake_pulse && cpu_clk_en) begin
          check(0, "R8 cpu clock early", cpu_clk_en, 0);
        end
      end
      slow_tick = 0;
      check(seen_at == 3, "R8 settle ticks before release", seen_at, 3);
    end
    repeat (3) cycle();

    // R1: asynchronous reset from deep halt
    settle_cnt = '0; deep_halt_sel = 1; psr_ie = 0;
    halt_req = 1;
    cycle();
    halt_req = 0;
    check(bus_clk_en == 0, "R3 deep halt before reset", bus_clk_en, 0);
    #(CLK_PERIOD/4);
    rst_n = 0;
    #1;
    check(gates_now() == 6'h3f, "R1 async reset clears gating", gates_now(), 6'h3f);
    cycle();
    rst_n = 1;
    repeat (4) cycle();
    check(cpu_clk_en && !trap_req, "R1 run after reset", {cpu_clk_en, trap_req}, 2'b10);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule